// File: doc/BRIEF.md
# Stable Sorted Directory Insertion Table

This block keeps a fixed-capacity directory of records that is always ordered by a numeric order key. Records are added one at a time. Each insert brings an order key, an identifier, a size and a payload handle. The table finds where the new record belongs and moves every later record one slot higher, one move per clock cycle. It then writes the new record into the open slot. Every record that ends up at slot `i` carries the selector `SEL_BASE + i`, so selectors stay dense and match the sorted position.

A producer offers a record with `insValid` while `busy` is low. The block accepts it, rejects it because the table is full, or rejects it because the identifier is already present. Each outcome ends with a one-cycle `insDone` pulse and exactly one status flag. An insert whose key is not in the caller's priority list is marked with `insKnown` low and is filed with a last-place order value. A combinational read port returns the record count and any one slot. The count and the size fields on that port are byte-swapped to big-endian.

Top module: `dir_sorted_table`

## Requirements
- R1: After reset the record count is zero, every slot reads back as invalid (`rdValid` low) and `busy` is low.
- R2: After every successful insert the occupied slots are in non-decreasing key order. A new record whose key equals existing keys is placed after all of them, so equal keys keep their arrival order.
- R3: An insert offered while the count equals `DEPTH` raises `errFull` with `insDone` and leaves the count and all slots unchanged. Overflow takes priority over the duplicate check.
- R4: An insert whose identifier matches an occupied slot raises `errDup` with `insDone` and leaves the count and all slots unchanged.
- R5: Every occupied slot `i` reads back a selector equal to `SEL_BASE + i`. This includes records that were moved and the newly written one.
- R6: The count rises by exactly one on each successful insert and changes at no other time. `rdCountBe` holds the 32-bit count with its least significant byte in bits 31:24. `rdSizeBe` holds the size with its least significant byte in the top byte lane.
- R7: An insert with `insKnown` low is stored with key `DEFAULT_ORDER` (200), whatever value is on `insKey`.
- R8: One record moves per cycle. For an accepted insert placed at position p with count n, `insDone` comes n-p+1 cycles after the accepting edge, and `busy` is high until then. A rejected insert completes one cycle after it is offered.
- R9: `insValid` while `busy` is high is ignored. No record is added, no status is raised, and the table afterwards holds only what the ongoing insert produces.
- R10: `insDone` is asserted together with exactly one of `insOk`, `errFull` and `errDup`, and none of these flags appears without `insDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert request, sampled only while idle |
| insKnown | input | 1 | High: use `insKey`; low: use `DEFAULT_ORDER` |
| insKey | input | KEY_W | Order key of the new record |
| insId | input | ID_W | Identifier used for the duplicate check |
| insSize | input | SIZE_W | Size field of the new record |
| insHandle | input | HND_W | Payload handle of the new record |
| rdIdx | input | IDX_W | Slot selected on the read port |
| busy | output | 1 | Insert in progress |
| insDone | output | 1 | One-cycle completion pulse |
| insOk | output | 1 | Insert stored |
| errFull | output | 1 | Insert rejected, table full |
| errDup | output | 1 | Insert rejected, identifier present |
| rdCountBe | output | 32 | Record count, big-endian byte order |
| rdValid | output | 1 | Selected slot is occupied |
| rdKey | output | KEY_W | Key of selected slot |
| rdId | output | ID_W | Identifier of selected slot |
| rdSizeBe | output | SIZE_W | Size of selected slot, big-endian byte order |
| rdHandle | output | HND_W | Handle of selected slot |
| rdSel | output | SEL_W | Selector of selected slot |

## Verification
The bench builds the table with `DEPTH` = 5 and `SEL_BASE` = 0x20, keeping the default widths and last-place order value. The small depth lets one run fill the table and strike the overflow rejection. It also allows an insert at the front of a four-record table, which moves every record and gives the longest shift latency the configuration allows. Along the way the run covers equal keys, a last-place key, a repeated identifier and a request injected mid-shift.

// File: rtl/dir_table_pkg.sv
package dir_table_pkg;

  // Strobes from the sequencer to the record store
  typedef struct packed {
    logic loadNew;   // capture the offered record
    logic shiftOne;  // move slot cursor-1 up into slot cursor
    logic writeNew;  // place the captured record at slot cursor
  } dirStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_PLACE = 1'b1
  } dirState_t;

endpackage

// File: rtl/dir_table_ctrl.sv
module dir_table_ctrl
  import dir_table_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic             full,
  input  logic             dupHit,
  input  logic             keyLess,
  input  logic [CNT_W-1:0] count,
  output dirStrobe_t       strobe,
  output logic [IDX_W-1:0] cursor,
  output logic             busy,
  output logic             insDone,
  output logic             insOk,
  output logic             errFull,
  output logic             errDup
);

  dirState_t state;
  logic      moreToShift;

  assign busy        = (state == ST_PLACE);
  assign moreToShift = (cursor != '0) && keyLess;

  always_comb begin
    strobe = '0;
    if (state == ST_IDLE) begin
      strobe.loadNew = insValid && !full && !dupHit;
    end else if (moreToShift) begin
      strobe.shiftOne = 1'b1;
    end else begin
      strobe.writeNew = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cursor  <= '0;
      insDone <= 1'b0;
      insOk   <= 1'b0;
      errFull <= 1'b0;
      errDup  <= 1'b0;
    end else begin
      insDone <= 1'b0;
      insOk   <= 1'b0;
      errFull <= 1'b0;
      errDup  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (insValid) begin
            if (full) begin
              insDone <= 1'b1;
              errFull <= 1'b1;
            end else if (dupHit) begin
              insDone <= 1'b1;
              errDup  <= 1'b1;
            end else begin
              state  <= ST_PLACE;
              cursor <= count[IDX_W-1:0];
            end
          end
        end
        ST_PLACE: begin
          if (moreToShift) begin
            cursor <= cursor - 1'b1;
          end else begin
            state   <= ST_IDLE;
            insDone <= 1'b1;
            insOk   <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dir_table_store.sv
module dir_table_store
  import dir_table_pkg::*;
#(
  parameter int              DEPTH         = 32,
  parameter int              KEY_W         = 8,
  parameter int              ID_W          = 8,
  parameter int              SIZE_W        = 32,
  parameter int              HND_W         = 16,
  parameter int              SEL_W         = 16,
  parameter logic [SEL_W-1:0] SEL_BASE     = 16'h0020,
  parameter logic [KEY_W-1:0] DEFAULT_ORDER = 8'd200,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SIZE_BYTES = SIZE_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobe_t        strobe,
  input  logic [IDX_W-1:0]  cursor,
  input  logic              insKnown,
  input  logic [KEY_W-1:0]  insKey,
  input  logic [ID_W-1:0]   insId,
  input  logic [SIZE_W-1:0] insSize,
  input  logic [HND_W-1:0]  insHandle,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              dupHit,
  output logic              keyLess,
  output logic [31:0]       rdCountBe,
  output logic              rdValid,
  output logic [KEY_W-1:0]  rdKey,
  output logic [ID_W-1:0]   rdId,
  output logic [SIZE_W-1:0] rdSizeBe,
  output logic [HND_W-1:0]  rdHandle,
  output logic [SEL_W-1:0]  rdSel
);

  logic              slotValid [DEPTH];
  logic [KEY_W-1:0]  keyArr    [DEPTH];
  logic [ID_W-1:0]   idArr     [DEPTH];
  logic [SIZE_W-1:0] sizeArr   [DEPTH];
  logic [HND_W-1:0]  hndArr    [DEPTH];
  logic [SEL_W-1:0]  selArr    [DEPTH];

  logic [KEY_W-1:0]  newKey;
  logic [ID_W-1:0]   newId;
  logic [SIZE_W-1:0] newSize;
  logic [HND_W-1:0]  newHandle;
  logic [DEPTH-1:0]  idMatch;
  logic [IDX_W-1:0]  prevIdx;
  logic [31:0]       countWide;

  // Captured record, key replaced by the last-place value when unknown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      newKey    <= '0;
      newId     <= '0;
      newSize   <= '0;
      newHandle <= '0;
    end else if (strobe.loadNew) begin
      newKey    <= insKnown ? insKey : DEFAULT_ORDER;
      newId     <= insId;
      newSize   <= insSize;
      newHandle <= insHandle;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.writeNew) begin
      count <= count + 1'b1;
    end
  end

  // One register set per slot; slot i is fed either by slot i-1 or by the new record
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam int SRC = (i == 0) ? 0 : i - 1;
    localparam logic [SEL_W-1:0] SLOT_SEL = SEL_BASE + SEL_W'(i);
    logic hitSlot;
    assign hitSlot = (cursor == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[i] <= 1'b0;
        keyArr[i]    <= '0;
        idArr[i]     <= '0;
        sizeArr[i]   <= '0;
        hndArr[i]    <= '0;
        selArr[i]    <= '0;
      end else if (strobe.shiftOne && hitSlot && (i != 0)) begin
        slotValid[i] <= 1'b1;
        keyArr[i]    <= keyArr[SRC];
        idArr[i]     <= idArr[SRC];
        sizeArr[i]   <= sizeArr[SRC];
        hndArr[i]    <= hndArr[SRC];
        selArr[i]    <= SLOT_SEL;
      end else if (strobe.writeNew && hitSlot) begin
        slotValid[i] <= 1'b1;
        keyArr[i]    <= newKey;
        idArr[i]     <= newId;
        sizeArr[i]   <= newSize;
        hndArr[i]    <= newHandle;
        selArr[i]    <= SLOT_SEL;
      end
    end

    assign idMatch[i] = slotValid[i] && (idArr[i] == insId);
  end

  assign dupHit  = |idMatch;
  assign full    = (count == CNT_W'(DEPTH));
  assign prevIdx = cursor - 1'b1;
  assign keyLess = (cursor != '0) && (newKey < keyArr[prevIdx]);

  // Read port
  assign countWide = 32'(count);
  assign rdCountBe = {countWide[7:0], countWide[15:8], countWide[23:16], countWide[31:24]};
  assign rdValid   = slotValid[rdIdx];
  assign rdKey     = keyArr[rdIdx];
  assign rdId      = idArr[rdIdx];
  assign rdHandle  = hndArr[rdIdx];
  assign rdSel     = selArr[rdIdx];

  always_comb begin
    for (int b = 0; b < SIZE_BYTES; b++) begin
      rdSizeBe[b*8 +: 8] = sizeArr[rdIdx][SIZE_W-8-b*8 +: 8];
    end
  end

endmodule

// File: rtl/dir_sorted_table.sv
module dir_sorted_table
  import dir_table_pkg::*;
#(
  parameter int              DEPTH         = 32,
  parameter int              KEY_W         = 8,
  parameter int              ID_W          = 8,
  parameter int              SIZE_W        = 32,
  parameter int              HND_W         = 16,
  parameter int              SEL_W         = 16,
  parameter logic [SEL_W-1:0] SEL_BASE     = 16'h0020,
  parameter logic [KEY_W-1:0] DEFAULT_ORDER = 8'd200,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic              insKnown,
  input  logic [KEY_W-1:0]  insKey,
  input  logic [ID_W-1:0]   insId,
  input  logic [SIZE_W-1:0] insSize,
  input  logic [HND_W-1:0]  insHandle,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              busy,
  output logic              insDone,
  output logic              insOk,
  output logic              errFull,
  output logic              errDup,
  output logic [31:0]       rdCountBe,
  output logic              rdValid,
  output logic [KEY_W-1:0]  rdKey,
  output logic [ID_W-1:0]   rdId,
  output logic [SIZE_W-1:0] rdSizeBe,
  output logic [HND_W-1:0]  rdHandle,
  output logic [SEL_W-1:0]  rdSel
);

  dirStrobe_t       strobe;
  logic [IDX_W-1:0] cursor;
  logic [CNT_W-1:0] tableCount;
  logic             full;
  logic             dupHit;
  logic             keyLess;

  dir_table_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid),
    .full(full), .dupHit(dupHit), .keyLess(keyLess), .count(tableCount),
    .strobe(strobe), .cursor(cursor), .busy(busy),
    .insDone(insDone), .insOk(insOk), .errFull(errFull), .errDup(errDup)
  );

  dir_table_store #(
    .DEPTH(DEPTH), .KEY_W(KEY_W), .ID_W(ID_W), .SIZE_W(SIZE_W),
    .HND_W(HND_W), .SEL_W(SEL_W), .SEL_BASE(SEL_BASE), .DEFAULT_ORDER(DEFAULT_ORDER)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cursor(cursor),
    .insKnown(insKnown), .insKey(insKey), .insId(insId),
    .insSize(insSize), .insHandle(insHandle), .rdIdx(rdIdx),
    .count(tableCount), .full(full), .dupHit(dupHit), .keyLess(keyLess),
    .rdCountBe(rdCountBe), .rdValid(rdValid), .rdKey(rdKey), .rdId(rdId),
    .rdSizeBe(rdSizeBe), .rdHandle(rdHandle), .rdSel(rdSel)
  );

endmodule

// File: rtl/dir_table_checker.sv
module dir_table_checker #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             insValid,
  input logic             busy,
  input logic             insDone,
  input logic             insOk,
  input logic             errFull,
  input logic             errDup,
  input logic [CNT_W-1:0] count
);

  assert_done_one_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    insDone |-> ($countones({insOk, errFull, errDup}) == 1));

  assert_status_needs_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (insOk || errFull || errDup) |-> insDone);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> ((count == $past(count) + 1'b1) && insOk));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  assert_full_reject_R3: assert property (@(posedge clk) disable iff (!rstN)
    errFull |-> (count == CNT_W'(DEPTH)));

  assert_busy_no_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !insDone);

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && insValid) |=> (!errFull && !errDup));

endmodule

bind dir_sorted_table dir_table_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_checker (
  .clk(clk), .rstN(rstN), .insValid(insValid), .busy(busy),
  .insDone(insDone), .insOk(insOk), .errFull(errFull), .errDup(errDup),
  .count(tableCount)
);

// File: tb/test_dir_sorted_table.sv
module test_dir_sorted_table;

  localparam int DEPTH  = 5;
  localparam int KEY_W  = 8;
  localparam int ID_W   = 8;
  localparam int SIZE_W = 32;
  localparam int HND_W  = 16;
  localparam int SEL_W  = 16;
  localparam logic [SEL_W-1:0] BASE = 16'h0020;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int ST_OK = 0, ST_FULL = 1, ST_DUP = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insValid = 1'b0, insKnown = 1'b1;
  logic [KEY_W-1:0]  insKey = '0;
  logic [ID_W-1:0]   insId = '0;
  logic [SIZE_W-1:0] insSize = '0;
  logic [HND_W-1:0]  insHandle = '0;
  logic [IDX_W-1:0]  rdIdx = '0;
  logic busy, insDone, insOk, errFull, errDup, rdValid;
  logic [31:0] rdCountBe;
  logic [KEY_W-1:0] rdKey;
  logic [ID_W-1:0] rdId;
  logic [SIZE_W-1:0] rdSizeBe;
  logic [HND_W-1:0] rdHandle;
  logic [SEL_W-1:0] rdSel;

  int checks = 0, failures = 0, cyc = 0, doneSeen = 0, pushed = 0;
  int qStat[$], qLat[$], qCyc[$];
  logic [KEY_W-1:0]  mKey [DEPTH];
  logic [ID_W-1:0]   mId  [DEPTH];
  logic [SIZE_W-1:0] mSize[DEPTH];
  logic [HND_W-1:0]  mHnd [DEPTH];
  int mCount = 0;

  dir_sorted_table #(.DEPTH(DEPTH), .KEY_W(KEY_W), .ID_W(ID_W), .SIZE_W(SIZE_W),
    .HND_W(HND_W), .SEL_W(SEL_W), .SEL_BASE(BASE), .DEFAULT_ORDER(8'd200)) i_dir_sorted_table (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insKnown(insKnown), .insKey(insKey),
    .insId(insId), .insSize(insSize), .insHandle(insHandle), .rdIdx(rdIdx),
    .busy(busy), .insDone(insDone), .insOk(insOk), .errFull(errFull), .errDup(errDup),
    .rdCountBe(rdCountBe), .rdValid(rdValid), .rdKey(rdKey), .rdId(rdId),
    .rdSizeBe(rdSizeBe), .rdHandle(rdHandle), .rdSel(rdSel));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Watchdog
  initial begin
    wait (cyc > 20000);
    failures++;
    $display("FAIL watchdog actual=%0d expected<20000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // Monitor: pops expected status and latency on every completion
  always @(negedge clk) begin
    if (rstN && insDone) begin
      if (qStat.size() == 0) begin
        check("R10 unexpected done", 1'b0, 1, 0);
      end else begin
        int st, lat, c0;
        st = qStat.pop_front(); lat = qLat.pop_front(); c0 = qCyc.pop_front();
        check("R10 status", {insOk, errFull, errDup} ==
              {st == ST_OK, st == ST_FULL, st == ST_DUP},
              {insOk, errFull, errDup}, {st == ST_OK, st == ST_FULL, st == ST_DUP});
        check("R8 latency", (cyc - c0) == lat, cyc - c0, lat);
      end
      doneSeen++;
    end
  end

  // Model update plus expected status/latency; returns nothing
  task automatic modelInsert(input bit known, input logic [KEY_W-1:0] key,
                             input logic [ID_W-1:0] id, input logic [SIZE_W-1:0] sz,
                             input logic [HND_W-1:0] hnd);
    logic [KEY_W-1:0] k;
    bit dup = 0;
    int pos;
    k = known ? key : 8'd200;
    for (int i = 0; i < mCount; i++) if (mId[i] == id) dup = 1;
    qCyc.push_back(cyc);
    if (mCount == DEPTH) begin
      qStat.push_back(ST_FULL); qLat.push_back(1);
    end else if (dup) begin
      qStat.push_back(ST_DUP); qLat.push_back(1);
    end else begin
      pos = mCount;
      while (pos > 0 && k < mKey[pos-1]) pos--;
      for (int i = mCount; i > pos; i--) begin
        mKey[i] = mKey[i-1]; mId[i] = mId[i-1]; mSize[i] = mSize[i-1]; mHnd[i] = mHnd[i-1];
      end
      mKey[pos] = k; mId[pos] = id; mSize[pos] = sz; mHnd[pos] = hnd;
      qStat.push_back(ST_OK); qLat.push_back(mCount - pos + 2);
      mCount++;
    end
    pushed++;
  endtask

  task automatic drive(input bit known, input logic [KEY_W-1:0] key,
                       input logic [ID_W-1:0] id, input logic [SIZE_W-1:0] sz,
                       input logic [HND_W-1:0] hnd);
    insKnown = known; insKey = key; insId = id; insSize = sz; insHandle = hnd;
    insValid = 1'b1;
  endtask

  task automatic doInsert(input bit known, input logic [KEY_W-1:0] key,
                          input logic [ID_W-1:0] id, input logic [SIZE_W-1:0] sz,
                          input logic [HND_W-1:0] hnd, input bit inject);
    @(negedge clk);
    modelInsert(known, key, id, sz, hnd);
    drive(known, key, id, sz, hnd);
    @(negedge clk);
    insValid = 1'b0;
    if (inject) begin
      check("R8 busy during shift", busy == 1'b1, busy, 1);
      drive(1'b1, 8'd1, 8'hEE, 32'h0, 16'h0);  // R9: must be ignored
      @(negedge clk);
      insValid = 1'b0;
    end
    while (doneSeen < pushed) @(negedge clk);
  endtask

  task automatic checkTable(input string tag);
    logic [31:0] c;
    c = 32'(mCount);
    @(negedge clk);
    check({"R6 count ", tag}, rdCountBe == {c[7:0], c[15:8], c[23:16], c[31:24]},
          rdCountBe, {c[7:0], c[15:8], c[23:16], c[31:24]});
    check({"R8 idle ", tag}, busy == 1'b0, busy, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rdIdx = IDX_W'(i);
      #1;
      check({"R1 valid ", tag}, rdValid == (i < mCount), rdValid, i < mCount);
      if (i < mCount) begin
        check({"R2 key ", tag}, rdKey == mKey[i], rdKey, mKey[i]);
        check({"R2 id ", tag}, rdId == mId[i], rdId, mId[i]);
        check({"R6 size ", tag}, rdSizeBe == {mSize[i][7:0], mSize[i][15:8], mSize[i][23:16], mSize[i][31:24]},
              rdSizeBe, {mSize[i][7:0], mSize[i][15:8], mSize[i][23:16], mSize[i][31:24]});
        check({"R2 handle ", tag}, rdHandle == mHnd[i], rdHandle, mHnd[i]);
        check({"R5 sel ", tag}, rdSel == BASE + SEL_W'(i), rdSel, BASE + SEL_W'(i));
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkTable("R1 reset");
    doInsert(1, 8'd50, 8'h01, 32'h11223344, 16'hA001, 0);
    checkTable("first");
    doInsert(1, 8'd30, 8'h02, 32'h00000102, 16'hA002, 0);   // R2 shift one
    checkTable("front");
    doInsert(1, 8'd50, 8'h03, 32'hCAFEF00D, 16'hA003, 0);   // R2 equal key stays after
    checkTable("stable");
    doInsert(0, 8'd5, 8'h04, 32'h00000004, 16'hA004, 0);    // R7 unknown key -> 200
    checkTable("R7 default");
    doInsert(1, 8'd40, 8'h02, 32'h99, 16'hBAD0, 0);         // R4 duplicate id
    checkTable("R4 dup");
    doInsert(1, 8'd10, 8'h05, 32'h55667788, 16'hA005, 1);   // R8 four shifts, R9 inject
    checkTable("R9 ignore");
    doInsert(1, 8'd20, 8'h06, 32'h1, 16'hBAD1, 0);          // R3 full
    checkTable("R3 full");
    doInsert(1, 8'd20, 8'h01, 32'h1, 16'hBAD2, 0);          // R3 full beats duplicate
    checkTable("R3 priority");
    check("R10 all done", doneSeen == pushed && qStat.size() == 0, doneSeen, pushed);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule